// File: doc/BRIEF.md
# Codec power sequencing controller

This block is a finite-state controller that powers an audio DAC and its headphone amplifier up and down in a fixed order. It holds the codec's power-down line low for a minimum time after chip reset, then releases it. It brings up the reference, PLL, DAC core and clock-output enables, waits for PLL lock, and opens the left and right DAC-to-headphone paths. If the 3D option was requested, it sets the 3D mode field. It then waits a settling time that depends on the mode. Last, it enables the amplifiers, releases mute, and raises the attenuation from mute to full level.

Teardown runs in the reverse order. The attenuation returns to mute first, and the attenuator ramp time is allowed to pass. The amplifiers are switched off only once the codec reports that its headphone outputs have fallen low. The paths, the 3D field and the core enables are then cleared. Every wait is a count of system clock cycles set by a parameter. If lock is not seen within its limit, the controller parks in a fault state with all enables off.

The block carries no data stream. All of its pins are plain control and status levels, sampled or driven on the rising clock edge, so there is no valid/ready handshake and no back-pressure.

Top module: `pwr_seq_ctrl`

## Requirements
- R1: During reset and for HOLD_CYC cycles after it, `rst_o` is low, every enable is low, `atten` is 8'h00 and `busy` is high; `rst_o` then rises, which marks the off state.
- R2: A power-up request accepted in the off state raises `en_vref`, `en_pll`, `en_dac` and `en_mclk` together in the next cycle, while both path enables are still low.
- R3: While waiting for lock, the path enables rise in the cycle after `pll_lock` is sampled high. A lock seen in the very cycle the lock timeout expires wins over the timeout.
- R4: If `pll_lock` stays low for LOCK_CYC cycles after the core enables rise, the block enters a fault state. In that state `fault` is high, `rst_o` is high and every enable is low. Only a power-down request leaves it, returning to the off state.
- R5: `fx_en` is sampled only when a power-up request is accepted. When it was set, `fx3d` becomes 2'b10 one cycle after the path enables rise; otherwise `fx3d` stays 2'b00 for the whole sequence.
- R6: `amp_l`, `amp_r` and `unmute` rise exactly SETTLE_CYC cycles after the path enables when 3D is off. When 3D is on, they rise exactly SETTLE3D_CYC cycles after `fx3d` is set.
- R7: `atten` is only ever 8'h00 or 8'hFF. It is 8'hFF only while the amplifiers are on, it switches to 8'hFF in the same cycle the amplifiers rise, and `busy` falls RAMP_CYC cycles later (normal operation).
- R8: A power-down request in normal operation sets `atten` to 8'h00 in the next cycle. The amplifiers stay on for at least RAMP_CYC+1 cycles after that, and until `hp_low` is sampled high after the ramp.
- R9: Teardown clears `amp_l`, `amp_r` and `unmute` first. One cycle later it clears the path enables, `fx3d` and the four core enables together, ending in the off state.
- R10: A power-up request has effect only in the off state. A power-down request has effect only in normal operation and in the fault state. `busy` is low exactly in the off state and in normal operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| up_req | input | 1 | Power-up request, level sampled each cycle |
| dn_req | input | 1 | Power-down request, level sampled each cycle |
| fx_en | input | 1 | Use the 3D mode on the next power-up |
| pll_lock | input | 1 | Codec PLL reports lock |
| hp_low | input | 1 | Codec headphone outputs have fallen low |
| rst_o | output | 1 | Codec power-down line, high = released |
| en_vref | output | 1 | Reference enable |
| en_pll | output | 1 | PLL enable |
| en_dac | output | 1 | DAC core enable |
| en_mclk | output | 1 | Clock-output enable |
| path_l | output | 1 | Left DAC-to-headphone path enable |
| path_r | output | 1 | Right DAC-to-headphone path enable |
| fx3d | output | 2 | 3D mode field: 2'b00 off, 2'b10 on |
| amp_l | output | 1 | Left headphone amplifier enable |
| amp_r | output | 1 | Right headphone amplifier enable |
| unmute | output | 1 | Mute release |
| atten | output | 8 | Attenuation: 8'h00 mute, 8'hFF full level |
| busy | output | 1 | High while a sequence is in progress or in fault |
| fault | output | 1 | Lock timeout fault |

## Verification
Two functions can collide in the same cycle: lock detection and lock timeout, when `pll_lock` first goes high in the last cycle of the lock window. The bench counts cycles from the visible rise of the core enables and raises `pll_lock` so that it is sampled exactly at the expiry edge. It then expects the path enables to rise exactly LOCK_CYC cycles after the core enables, with `fault` never set. A separate run holds lock low to show that the same edge otherwise lands in the fault state.

// File: rtl/seq_pkg.sv
`timescale 1ns/1ps
package seq_pkg;

  typedef enum logic [3:0] {
    ST_HOLD, ST_OFF, ST_CORE, ST_PATH, ST_FX, ST_AMP,
    ST_RUN, ST_MUTE, ST_DRAIN, ST_AMPOFF, ST_FAULT
  } seq_st_e;

  // decoded control levels for one state
  typedef struct packed {
    logic rel;    // power-down line released
    logic core;   // reference, PLL, DAC core, clock output
    logic path;   // left/right path enables
    logic fx;     // 3D field active
    logic amp;    // amplifiers and mute release
    logic loud;   // attenuation at full level
    logic busy;
    logic fault;
  } seq_ctl_t;

  localparam logic [1:0] FX_CODE_ON  = 2'b10;
  localparam logic [1:0] FX_CODE_OFF = 2'b00;
  localparam logic [7:0] ATT_MUTE    = 8'h00;
  localparam logic [7:0] ATT_FULL    = 8'hFF;

endpackage

// File: rtl/seq_timer.sv
`timescale 1ns/1ps
module seq_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  output logic [CW-1:0] cnt
);
  localparam logic [CW-1:0] CNT_TOP = {CW{1'b1}};

  // counts cycles spent in the current state, zero on entry, saturating
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (restart)      cnt <= '0;
    else if (cnt != CNT_TOP) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/seq_fsm.sv
`timescale 1ns/1ps
module seq_fsm
  import seq_pkg::*;
#(
  parameter int CW           = 8,
  parameter int HOLD_CYC     = 4,
  parameter int LOCK_CYC     = 20,
  parameter int SETTLE_CYC   = 6,
  parameter int SETTLE3D_CYC = 14,
  parameter int RAMP_CYC     = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] cnt,
  input  logic          up_req,
  input  logic          dn_req,
  input  logic          fx_en,
  input  logic          pll_lock,
  input  logic          hp_low,
  output seq_st_e       st_q,
  output logic          fx_mode,
  output logic          restart
);
  // a state lasts N cycles when it leaves at count N-1
  localparam logic [CW-1:0] HOLD_LAST   = CW'(HOLD_CYC - 1);
  localparam logic [CW-1:0] LOCK_LAST   = CW'(LOCK_CYC - 1);
  localparam logic [CW-1:0] SETTLE_LAST = CW'(SETTLE_CYC - 1);
  localparam logic [CW-1:0] S3D_LAST    = CW'(SETTLE3D_CYC - 1);
  localparam logic [CW-1:0] RAMP_LAST   = CW'(RAMP_CYC - 1);

  seq_st_e st_d;
  logic    fx_mode_q;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_HOLD:   if (cnt == HOLD_LAST) st_d = ST_OFF;
      ST_OFF:    if (up_req) st_d = ST_CORE;
      // lock is checked before the timeout so a late lock still wins
      ST_CORE:   if (pll_lock) st_d = ST_PATH;
                 else if (cnt == LOCK_LAST) st_d = ST_FAULT;
      ST_PATH:   if (fx_mode_q) st_d = ST_FX;
                 else if (cnt == SETTLE_LAST) st_d = ST_AMP;
      ST_FX:     if (cnt == S3D_LAST) st_d = ST_AMP;
      ST_AMP:    if (cnt == RAMP_LAST) st_d = ST_RUN;
      ST_RUN:    if (dn_req) st_d = ST_MUTE;
      ST_MUTE:   if (cnt == RAMP_LAST) st_d = ST_DRAIN;
      ST_DRAIN:  if (hp_low) st_d = ST_AMPOFF;
      ST_AMPOFF: st_d = ST_OFF;
      ST_FAULT:  if (dn_req) st_d = ST_OFF;
      default:   st_d = ST_HOLD;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_HOLD;
      fx_mode_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (st_q == ST_OFF && up_req) fx_mode_q <= fx_en;
    end
  end

  assign restart = (st_d != st_q);
  assign fx_mode = fx_mode_q;
endmodule

// File: rtl/seq_outdec.sv
`timescale 1ns/1ps
module seq_outdec
  import seq_pkg::*;
(
  input  seq_st_e  st,
  input  logic     fx_mode,
  output seq_ctl_t ctl
);
  always_comb begin
    ctl = '0;
    unique case (st)
      ST_HOLD:   ctl.busy = 1'b1;
      ST_OFF:    ctl.rel  = 1'b1;
      ST_CORE:   begin ctl.rel = 1'b1; ctl.core = 1'b1; ctl.busy = 1'b1; end
      ST_PATH:   begin ctl.rel = 1'b1; ctl.core = 1'b1; ctl.path = 1'b1; ctl.busy = 1'b1; end
      ST_FX:     begin
                   ctl.rel = 1'b1; ctl.core = 1'b1; ctl.path = 1'b1;
                   ctl.fx  = 1'b1; ctl.busy = 1'b1;
                 end
      ST_AMP:    begin
                   ctl.rel = 1'b1; ctl.core = 1'b1; ctl.path = 1'b1; ctl.fx = fx_mode;
                   ctl.amp = 1'b1; ctl.loud = 1'b1; ctl.busy = 1'b1;
                 end
      ST_RUN:    begin
                   ctl.rel = 1'b1; ctl.core = 1'b1; ctl.path = 1'b1; ctl.fx = fx_mode;
                   ctl.amp = 1'b1; ctl.loud = 1'b1;
                 end
      ST_MUTE, ST_DRAIN: begin
                   ctl.rel = 1'b1; ctl.core = 1'b1; ctl.path = 1'b1; ctl.fx = fx_mode;
                   ctl.amp = 1'b1; ctl.busy = 1'b1;
                 end
      ST_AMPOFF: begin
                   ctl.rel = 1'b1; ctl.core = 1'b1; ctl.path = 1'b1; ctl.fx = fx_mode;
                   ctl.busy = 1'b1;
                 end
      ST_FAULT:  begin ctl.rel = 1'b1; ctl.busy = 1'b1; ctl.fault = 1'b1; end
      default:   ctl.busy = 1'b1;
    endcase
  end
endmodule

// File: rtl/pwr_seq_ctrl.sv
`timescale 1ns/1ps
module pwr_seq_ctrl
  import seq_pkg::*;
#(
  parameter int HOLD_CYC     = 40,
  parameter int LOCK_CYC     = 7500000,
  parameter int SETTLE_CYC   = 500000,
  parameter int SETTLE3D_CYC = 12500000,
  parameter int RAMP_CYC     = 6020000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       up_req,
  input  logic       dn_req,
  input  logic       fx_en,
  input  logic       pll_lock,
  input  logic       hp_low,
  output logic       rst_o,
  output logic       en_vref,
  output logic       en_pll,
  output logic       en_dac,
  output logic       en_mclk,
  output logic       path_l,
  output logic       path_r,
  output logic [1:0] fx3d,
  output logic       amp_l,
  output logic       amp_r,
  output logic       unmute,
  output logic [7:0] atten,
  output logic       busy,
  output logic       fault
);
  localparam int MAX_A = (HOLD_CYC > LOCK_CYC) ? HOLD_CYC : LOCK_CYC;
  localparam int MAX_B = (SETTLE_CYC > SETTLE3D_CYC) ? SETTLE_CYC : SETTLE3D_CYC;
  localparam int MAX_C = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int MAX_L = (MAX_C > RAMP_CYC) ? MAX_C : RAMP_CYC;
  localparam int CW    = $clog2(MAX_L + 1);

  logic [CW-1:0] cnt;
  logic          restart;
  logic          fx_mode;
  seq_st_e       st_q;
  seq_ctl_t      ctl;

  seq_timer #(.CW(CW)) u_timer (
    .clk(clk), .rst_n(rst_n), .restart(restart), .cnt(cnt)
  );

  seq_fsm #(
    .CW(CW), .HOLD_CYC(HOLD_CYC), .LOCK_CYC(LOCK_CYC),
    .SETTLE_CYC(SETTLE_CYC), .SETTLE3D_CYC(SETTLE3D_CYC), .RAMP_CYC(RAMP_CYC)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .cnt(cnt), .up_req(up_req), .dn_req(dn_req),
    .fx_en(fx_en), .pll_lock(pll_lock), .hp_low(hp_low),
    .st_q(st_q), .fx_mode(fx_mode), .restart(restart)
  );

  seq_outdec u_dec (.st(st_q), .fx_mode(fx_mode), .ctl(ctl));

  assign rst_o   = ctl.rel;
  assign en_vref = ctl.core;
  assign en_pll  = ctl.core;
  assign en_dac  = ctl.core;
  assign en_mclk = ctl.core;
  assign path_l  = ctl.path;
  assign path_r  = ctl.path;
  assign fx3d    = ctl.fx ? FX_CODE_ON : FX_CODE_OFF;
  assign amp_l   = ctl.amp;
  assign amp_r   = ctl.amp;
  assign unmute  = ctl.amp;
  assign atten   = ctl.loud ? ATT_FULL : ATT_MUTE;
  assign busy    = ctl.busy;
  assign fault   = ctl.fault;
endmodule

// File: rtl/seq_chk.sv
`timescale 1ns/1ps
module seq_chk #(
  parameter int SETTLE_CYC   = 6,
  parameter int SETTLE3D_CYC = 14
) (
  input logic       clk,
  input logic       rst_n,
  input logic       up_req,
  input logic       pll_lock,
  input logic       hp_low,
  input logic       rst_o,
  input logic       en_pll,
  input logic       en_dac,
  input logic       path_l,
  input logic       path_r,
  input logic [1:0] fx3d,
  input logic       amp_l,
  input logic       amp_r,
  input logic       unmute,
  input logic [7:0] atten,
  input logic       busy,
  input logic       fault
);
  int unsigned path_run;
  int unsigned fx_run;

  // cycles the path enables and the 3D field have been continuously set
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      path_run <= 0;
      fx_run   <= 0;
    end else begin
      path_run <= !path_l ? 0 : (path_run == 32'hFFFF_FFFF ? path_run : path_run + 1);
      fx_run   <= (fx3d == 2'b00) ? 0 : (fx_run == 32'hFFFF_FFFF ? fx_run : fx_run + 1);
    end
  end

  a_r1_held_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !rst_o |-> (!en_pll && !path_l && !amp_l && atten == 8'h00));

  a_r2_core_first: assert property (@(posedge clk) disable iff (!rst_n)
    (path_l || path_r) |-> (en_pll && en_dac && rst_o));

  a_r3_path_on_lock: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(path_l) |-> $past(pll_lock));

  a_r4_fault_dark: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> (!en_pll && !path_l && !amp_l && rst_o));

  a_r5_fx_legal: assert property (@(posedge clk) disable iff (!rst_n)
    (fx3d != 2'b00) |-> (fx3d == 2'b10 && path_l && path_r));

  a_r6_plain_settle: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(amp_l) && fx3d == 2'b00) |-> (path_run >= SETTLE_CYC));

  a_r6_fx_settle: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(amp_l) && fx3d == 2'b10) |-> (fx_run >= SETTLE3D_CYC));

  a_r7_atten_levels: assert property (@(posedge clk) disable iff (!rst_n)
    (atten != 8'h00) |-> (atten == 8'hFF && amp_l && amp_r && unmute));

  a_r8_amp_off_on_low: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(amp_l) |-> $past(hp_low));

  a_r9_path_after_amp: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(path_l) |-> ($past(!amp_l) && fx3d == 2'b00 && !en_pll));

  a_r10_accept_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(en_pll) |-> ($past(up_req) && !$past(busy)));
endmodule

bind pwr_seq_ctrl seq_chk #(
  .SETTLE_CYC(SETTLE_CYC), .SETTLE3D_CYC(SETTLE3D_CYC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .up_req(up_req), .pll_lock(pll_lock), .hp_low(hp_low),
  .rst_o(rst_o), .en_pll(en_pll), .en_dac(en_dac), .path_l(path_l), .path_r(path_r),
  .fx3d(fx3d), .amp_l(amp_l), .amp_r(amp_r), .unmute(unmute), .atten(atten),
  .busy(busy), .fault(fault)
);

// File: tb/sim_pwr_seq_ctrl.sv
`timescale 1ns/1ps
module sim_pwr_seq_ctrl;
  localparam int HOLD   = 4;
  localparam int LOCK   = 20;
  localparam int SETTLE = 6;
  localparam int S3D    = 14;
  localparam int RAMP   = 9;
  localparam int BIG    = 100000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic up_req = 1'b0, dn_req = 1'b0, fx_en = 1'b0, pll_lock = 1'b0, hp_low = 1'b0;
  logic rst_o, en_vref, en_pll, en_dac, en_mclk, path_l, path_r;
  logic [1:0] fx3d;
  logic amp_l, amp_r, unmute, busy, fault;
  logic [7:0] atten;

  always #2 clk = ~clk;

  pwr_seq_ctrl #(
    .HOLD_CYC(HOLD), .LOCK_CYC(LOCK), .SETTLE_CYC(SETTLE),
    .SETTLE3D_CYC(S3D), .RAMP_CYC(RAMP)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .up_req(up_req), .dn_req(dn_req), .fx_en(fx_en),
    .pll_lock(pll_lock), .hp_low(hp_low), .rst_o(rst_o), .en_vref(en_vref),
    .en_pll(en_pll), .en_dac(en_dac), .en_mclk(en_mclk), .path_l(path_l),
    .path_r(path_r), .fx3d(fx3d), .amp_l(amp_l), .amp_r(amp_r), .unmute(unmute),
    .atten(atten), .busy(busy), .fault(fault)
  );

  wire [21:0] obs = {rst_o, en_vref, en_pll, en_dac, en_mclk, path_l, path_r, fx3d,
                     amp_l, amp_r, unmute, atten, busy, fault};

  typedef struct {
    logic [21:0] v;
    int          gmin;
    int          gmax;
    string       tag;
  } exp_t;

  exp_t q[$];
  int n_chk = 0;
  int n_bad = 0;

  function automatic logic [21:0] mk(bit rel, bit core, bit path, bit fx, bit amp,
                                     bit loud, bit bz, bit flt);
    return {rel, {4{core}}, {2{path}}, (fx ? 2'b10 : 2'b00), {2{amp}}, amp,
            (loud ? 8'hFF : 8'h00), bz, flt};
  endfunction

  // named bundles
  wire [21:0] B_HOLD  = mk(0,0,0,0,0,0,1,0);
  wire [21:0] B_OFF   = mk(1,0,0,0,0,0,0,0);
  wire [21:0] B_CORE  = mk(1,1,0,0,0,0,1,0);
  wire [21:0] B_PATH  = mk(1,1,1,0,0,0,1,0);
  wire [21:0] B_FX    = mk(1,1,1,1,0,0,1,0);
  wire [21:0] B_AMP   = mk(1,1,1,0,1,1,1,0);
  wire [21:0] B_RUN   = mk(1,1,1,0,1,1,0,0);
  wire [21:0] B_MUTE  = mk(1,1,1,0,1,0,1,0);
  wire [21:0] B_AOFF  = mk(1,1,1,0,0,0,1,0);
  wire [21:0] B_AMP3  = mk(1,1,1,1,1,1,1,0);
  wire [21:0] B_RUN3  = mk(1,1,1,1,1,1,0,0);
  wire [21:0] B_MUTE3 = mk(1,1,1,1,1,0,1,0);
  wire [21:0] B_AOFF3 = mk(1,1,1,1,0,0,1,0);
  wire [21:0] B_FLT   = mk(1,0,0,0,0,0,1,1);

  task automatic check(bit ok, string tag, logic [21:0] act, logic [21:0] exp_v);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp_v);
    end
  endtask

  task automatic push(logic [21:0] v, int gmin, int gmax, string tag);
    exp_t e;
    e.v = v; e.gmin = gmin; e.gmax = gmax; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  // monitor: every change of the output bundle must match the next expected item
  initial begin
    logic [21:0] prev;
    int gap;
    @(posedge rst_n);
    prev = obs;
    gap  = 0;
    forever begin
      @(negedge clk);
      gap++;
      if (obs !== prev) begin
        if (q.size() == 0) begin
          n_chk++; n_bad++;
          $display("FAIL unexpected output change actual=%h expected=%h", obs, prev);
        end else begin
          exp_t e;
          e = q.pop_front();
          check(obs === e.v, {e.tag, " value"}, obs, e.v);
          n_chk++;
          if (gap < e.gmin || gap > e.gmax) begin
            n_bad++;
            $display("FAIL %s gap actual=%0d expected=%0d..%0d", e.tag, gap, e.gmin, e.gmax);
          end
        end
        prev = obs;
        gap  = 0;
      end
    end
  end

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    // R1: reset state
    cyc(3);
    check(obs === B_HOLD, "R1 reset state", obs, B_HOLD);
    push(B_OFF, HOLD, HOLD, "R1 hold release");
    rst_n = 1'b1;
    cyc(HOLD + 3);

    // R10: power-down request in the off state has no effect
    dn_req = 1'b1; cyc(1); dn_req = 1'b0; cyc(4);
    check(obs === B_OFF, "R10 dn ignored when off", obs, B_OFF);

    // R2, R3: power-up without 3D, lock sampled in the last timeout cycle
    push(B_CORE, 1, BIG, "R2 core enables");
    push(B_PATH, LOCK, LOCK, "R3 lock at timeout edge");
    push(B_AMP, SETTLE, SETTLE, "R6 plain settle");
    push(B_RUN, RAMP, RAMP, "R7 ramp before run");
    fx_en = 1'b0; up_req = 1'b1; cyc(1); up_req = 1'b0;
    cyc(LOCK - 1); pll_lock = 1'b1;
    cyc(SETTLE + RAMP + 5);
    pll_lock = 1'b0;

    // R10: power-up request in normal operation has no effect
    up_req = 1'b1; cyc(1); up_req = 1'b0; cyc(4);
    check(obs === B_RUN, "R10 up ignored when running", obs, B_RUN);

    // R8, R9: power-down with outputs already low
    hp_low = 1'b1;
    push(B_MUTE, 1, BIG, "R8 mute first");
    push(B_AOFF, RAMP + 1, RAMP + 1, "R8 amps held for ramp");
    push(B_OFF, 1, 1, "R9 paths after amps");
    dn_req = 1'b1; cyc(1); dn_req = 1'b0;
    cyc(RAMP + 6);

    // R5, R6: power-up with 3D; option dropped after acceptance
    hp_low = 1'b0;
    push(B_CORE, 1, BIG, "R2 core enables 3D");
    push(B_PATH, 1, BIG, "R3 path after lock 3D");
    push(B_FX, 1, 1, "R5 fx after path");
    push(B_AMP3, S3D, S3D, "R6 3D settle");
    push(B_RUN3, RAMP, RAMP, "R7 ramp before run 3D");
    fx_en = 1'b1; up_req = 1'b1; cyc(1); up_req = 1'b0; fx_en = 1'b0;
    cyc(3); pll_lock = 1'b1;
    cyc(2 + S3D + RAMP + 5);
    pll_lock = 1'b0;

    // R8: teardown waits on the output-low indication
    push(B_MUTE3, 1, BIG, "R8 mute first 3D");
    push(B_AOFF3, RAMP + 1, BIG, "R8 amps off after low");
    push(B_OFF, 1, 1, "R9 paths and fx cleared");
    dn_req = 1'b1; cyc(1); dn_req = 1'b0;
    cyc(RAMP + 12);
    check(obs === B_MUTE3, "R8 amps held until output low", obs, B_MUTE3);
    hp_low = 1'b1;
    cyc(6);

    // R4: lock timeout
    push(B_CORE, 1, BIG, "R2 core enables timeout run");
    push(B_FLT, LOCK, LOCK, "R4 lock timeout");
    up_req = 1'b1; cyc(1); up_req = 1'b0;
    cyc(LOCK + 4);
    up_req = 1'b1; cyc(1); up_req = 1'b0; cyc(4);
    check(obs === B_FLT, "R10 up ignored in fault", obs, B_FLT);
    push(B_OFF, 1, BIG, "R4 fault exit");
    dn_req = 1'b1; cyc(1); dn_req = 1'b0;
    cyc(4);

    check(q.size() == 0, "R10 all expected changes seen", 22'(q.size()), 22'd0);
    finish_run();
  end
endmodule